// File: doc/BRIEF.md
# Retire Stall Watchdog with Event Counters

This block watches the retirement strobe of a processor core. It counts unbroken runs of clock cycles in which nothing retires. When such a run reaches a threshold that software programs, the block takes a single snapshot of the core's program counter, its control micro-state and the most recent exception vector, and it raises a frozen flag. The snapshot then stays put, even if the core recovers or wedges again, so a short-lived hang can still be examined long after it happened.

Alongside the watchdog, the block keeps a set of event counters. Two wide counters are free-running: one counts clock cycles and one counts retired instructions. Three narrower saturating counters record cycles without retirement, cycles spent waiting on I/O, and external interrupts taken. A one-cycle clear pulse resets every counter, the snapshot and the frozen flag together. A live status word packs the current micro-state, vector, I/O-wait level and frozen flag at fixed bit positions, for a register decoder elsewhere to read.

Top module: `stall_watch`

## Requirements
- R1: While rst_n is low, every counter output, snap_pc_o, snap_st_o and frozen_o read zero.
- R2: cyc_cnt_o increases by one on every clock edge that has clr_i low, and wraps at 2^WIDE_W.
- R3: ret_cnt_o increases by one on each edge where retire_i is high, and holds otherwise.
- R4: stall_cnt_o counts edges with retire_i low, io_cnt_o counts edges with io_wait_i high, and irq_cnt_o counts edges with irq_taken_i high.
- R5: stall_cnt_o, io_cnt_o and irq_cnt_o stop at all-ones (2^CNT_W-1) rather than wrapping.
- R6: When thresh_i is 0, frozen_o never sets, however long retirement is absent.
- R7: If thresh_i = N > 0 and retire_i is low on N consecutive edges, then at the Nth edge snap_pc_o takes pc_i and snap_st_o takes {frozen=1 in bit 14, vec_i in bits 13:6, fsm_i in bits 5:0}, all as sampled at that edge, and frozen_o goes high.
- R8: Any edge with retire_i high restarts the run, so N-1 stalls, one retire and N-1 more stalls leave frozen_o low.
- R9: While frozen_o is high, snap_pc_o and snap_st_o do not change, unless clr_i is applied.
- R10: An edge with clr_i high zeroes all counters, the snapshot, frozen_o and the internal run length. In that cycle clear takes priority over counting and over capture.
- R11: status_o is combinational: bits 5:0 = fsm_i, bits 15:8 = vec_i, bit 16 = io_wait_i, bit 18 = frozen_o, and all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | An instruction retired this cycle |
| pc_i | input | PC_W | Current core program counter |
| fsm_i | input | 6 | Current core micro-state |
| vec_i | input | 8 | Last exception or interrupt vector |
| io_wait_i | input | 1 | Core is parked waiting on I/O |
| irq_taken_i | input | 1 | External interrupt accepted this cycle |
| thresh_i | input | TH_W | Stall-run length that triggers capture; 0 disables |
| clr_i | input | 1 | One-cycle clear of counters, snapshot and flag |
| snap_pc_o | output | PC_W | Captured program counter |
| snap_st_o | output | 15 | Captured {frozen, vector, micro-state} |
| frozen_o | output | 1 | A snapshot is held |
| status_o | output | 32 | Live status word |
| cyc_cnt_o | output | WIDE_W | Cycle counter |
| ret_cnt_o | output | WIDE_W | Retired-instruction counter |
| stall_cnt_o | output | CNT_W | No-retire cycle counter |
| io_cnt_o | output | CNT_W | I/O-wait cycle counter |
| irq_cnt_o | output | CNT_W | Interrupts-taken counter |

## Verification
The counters are driven with a short mixed sequence of retire, I/O-wait and interrupt levels. Every combination of levels appears in it, so a counter wired to the wrong event, or one that counts the inverse level, shows up as a mismatch. The watchdog is tried four ways: with a zero threshold, with runs that stop one cycle short because a retire breaks them, with a run that lands exactly on the threshold, and with a further wedge after capture. Together these separate an off-by-one in the run length, a missing restart on retire, and a snapshot that gets overwritten. A clear that arrives in the same cycle as a stall shows whether clear really takes priority and whether the run length is reset. A long stall with the counters narrowed to 8 bits exposes wrap-around where saturation is required.

// File: rtl/stall_watch_pkg.sv
package stall_watch_pkg;
  localparam int FSM_W  = 6;
  localparam int VEC_W  = 8;
  localparam int SNAP_W = FSM_W + VEC_W + 1;
  localparam int STAT_W = 32;

  typedef struct packed {
    logic             frozen;
    logic [VEC_W-1:0] vec;
    logic [FSM_W-1:0] fsm;
  } snap_st_t;
endpackage

// File: rtl/sw_wrap_cnt.sv
module sw_wrap_cnt #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sw_sat_cnt.sv
module sw_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != TOP));
    cnt_d  = clr ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sw_freeze_cap.sv
module sw_freeze_cap
  import stall_watch_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int TH_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             retire,
  input  logic [PC_W-1:0]  pc,
  input  logic [FSM_W-1:0] fsm,
  input  logic [VEC_W-1:0] vec,
  input  logic [TH_W-1:0]  thresh,
  output logic [PC_W-1:0]  snap_pc,
  output snap_st_t         snap_st,
  output logic             frozen
);
  localparam logic [TH_W-1:0] RUN_TOP = {TH_W{1'b1}};

  logic [TH_W-1:0] run_q, run_d;
  logic            hit;
  logic            cap_en;
  logic            frz_q, frz_d;
  logic [PC_W-1:0] pc_q, pc_d;
  snap_st_t        st_q, st_d;

  // next-state logic
  always_comb begin
    if (clr || retire)        run_d = '0;
    else if (run_q != RUN_TOP) run_d = run_q + TH_W'(1);
    else                       run_d = run_q;

    hit    = !retire && (thresh != '0) && (run_d >= thresh) && !frz_q;
    cap_en = clr | hit;

    if (clr) begin
      pc_d  = '0;
      st_d  = '0;
      frz_d = 1'b0;
    end else begin
      pc_d      = pc;
      st_d.fsm  = fsm;
      st_d.vec  = vec;
      st_d.frozen = 1'b1;
      frz_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      st_q  <= '0;
      frz_q <= 1'b0;
    end else if (cap_en) begin
      pc_q  <= pc_d;
      st_q  <= st_d;
      frz_q <= frz_d;
    end
  end

  assign snap_pc = pc_q;
  assign snap_st = st_q;
  assign frozen  = frz_q;
endmodule

// File: rtl/stall_watch.sv
module stall_watch
  import stall_watch_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int TH_W   = 32,
  parameter int WIDE_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [FSM_W-1:0]  fsm_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              io_wait_i,
  input  logic              irq_taken_i,
  input  logic [TH_W-1:0]   thresh_i,
  input  logic              clr_i,
  output logic [PC_W-1:0]   snap_pc_o,
  output logic [SNAP_W-1:0] snap_st_o,
  output logic              frozen_o,
  output logic [STAT_W-1:0] status_o,
  output logic [WIDE_W-1:0] cyc_cnt_o,
  output logic [WIDE_W-1:0] ret_cnt_o,
  output logic [CNT_W-1:0]  stall_cnt_o,
  output logic [CNT_W-1:0]  io_cnt_o,
  output logic [CNT_W-1:0]  irq_cnt_o
);
  localparam int NSAT = 3;

  snap_st_t         snap_st;
  logic [NSAT-1:0]  sat_inc;
  logic [CNT_W-1:0] sat_val [NSAT];

  sw_wrap_cnt #(.W(WIDE_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .inc(1'b1), .cnt(cyc_cnt_o));

  sw_wrap_cnt #(.W(WIDE_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .inc(retire_i), .cnt(ret_cnt_o));

  assign sat_inc = {irq_taken_i, io_wait_i, ~retire_i};

  for (genvar g = 0; g < NSAT; g++) begin : g_sat
    sw_sat_cnt #(.W(CNT_W)) u_sat (
      .clk(clk), .rst_n(rst_n), .clr(clr_i), .inc(sat_inc[g]), .cnt(sat_val[g]));
  end

  assign stall_cnt_o = sat_val[0];
  assign io_cnt_o    = sat_val[1];
  assign irq_cnt_o   = sat_val[2];

  sw_freeze_cap #(.PC_W(PC_W), .TH_W(TH_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .retire(retire_i),
    .pc(pc_i), .fsm(fsm_i), .vec(vec_i), .thresh(thresh_i),
    .snap_pc(snap_pc_o), .snap_st(snap_st), .frozen(frozen_o));

  assign snap_st_o = snap_st;

  always_comb begin
    status_o        = '0;
    status_o[5:0]   = fsm_i;
    status_o[15:8]  = vec_i;
    status_o[16]    = io_wait_i;
    status_o[18]    = frozen_o;
  end
endmodule

// File: rtl/stall_watch_chk.sv
module stall_watch_chk #(
  parameter int PC_W   = 32,
  parameter int TH_W   = 32,
  parameter int WIDE_W = 64,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              retire_i,
  input logic [TH_W-1:0]   thresh_i,
  input logic              clr_i,
  input logic [PC_W-1:0]   snap_pc_o,
  input logic [14:0]       snap_st_o,
  input logic              frozen_o,
  input logic [WIDE_W-1:0] cyc_cnt_o,
  input logic [WIDE_W-1:0] ret_cnt_o,
  input logic [CNT_W-1:0]  stall_cnt_o
);
  // R2
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> cyc_cnt_o == $past(cyc_cnt_o) + WIDE_W'(1));

  // R3
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i && !clr_i) |=> $stable(ret_cnt_o));

  // R5
  stall_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> stall_cnt_o >= $past(stall_cnt_o));

  // R6
  zero_th_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh_i == '0 && !frozen_o) |=> !frozen_o);

  // R7
  cap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen_o) |-> $past(!retire_i && !clr_i && thresh_i != '0));

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_o && !clr_i) |=> ($stable(snap_pc_o) && $stable(snap_st_o) && frozen_o));

  // R10
  clr_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cyc_cnt_o == '0 && !frozen_o && stall_cnt_o == '0));
endmodule

bind stall_watch stall_watch_chk #(
  .PC_W(PC_W), .TH_W(TH_W), .WIDE_W(WIDE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .thresh_i(thresh_i),
  .clr_i(clr_i), .snap_pc_o(snap_pc_o), .snap_st_o(snap_st_o),
  .frozen_o(frozen_o), .cyc_cnt_o(cyc_cnt_o), .ret_cnt_o(ret_cnt_o),
  .stall_cnt_o(stall_cnt_o)
);

// File: tb/stall_watch_tb.sv
module stall_watch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int TH_W   = 32;
  localparam int WIDE_W = 64;
  localparam int CNT_W  = 8;

  // {retire, io, irq, exp_ret, exp_stall, exp_io, exp_irq}
  localparam logic [18:0] TBL [8] = '{
    {3'b100, 4'd1, 4'd0, 4'd0, 4'd0},
    {3'b010, 4'd1, 4'd1, 4'd1, 4'd0},
    {3'b011, 4'd1, 4'd2, 4'd2, 4'd1},
    {3'b101, 4'd2, 4'd2, 4'd2, 4'd2},
    {3'b110, 4'd3, 4'd2, 4'd3, 4'd2},
    {3'b000, 4'd3, 4'd3, 4'd3, 4'd2},
    {3'b001, 4'd3, 4'd4, 4'd3, 4'd3},
    {3'b111, 4'd4, 4'd4, 4'd4, 4'd4}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              retire_i, io_wait_i, irq_taken_i, clr_i;
  logic [PC_W-1:0]   pc_i;
  logic [5:0]        fsm_i;
  logic [7:0]        vec_i;
  logic [TH_W-1:0]   thresh_i;
  logic [PC_W-1:0]   snap_pc_o;
  logic [14:0]       snap_st_o;
  logic              frozen_o;
  logic [31:0]       status_o;
  logic [WIDE_W-1:0] cyc_cnt_o, ret_cnt_o;
  logic [CNT_W-1:0]  stall_cnt_o, io_cnt_o, irq_cnt_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stall_watch #(.PC_W(PC_W), .TH_W(TH_W), .WIDE_W(WIDE_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .pc_i(pc_i), .fsm_i(fsm_i),
    .vec_i(vec_i), .io_wait_i(io_wait_i), .irq_taken_i(irq_taken_i),
    .thresh_i(thresh_i), .clr_i(clr_i), .snap_pc_o(snap_pc_o),
    .snap_st_o(snap_st_o), .frozen_o(frozen_o), .status_o(status_o),
    .cyc_cnt_o(cyc_cnt_o), .ret_cnt_o(ret_cnt_o), .stall_cnt_o(stall_cnt_o),
    .io_cnt_o(io_cnt_o), .irq_cnt_o(irq_cnt_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear();
    clr_i = 1'b1;
    tick();
    clr_i = 1'b0;
  endtask

  task automatic stalls(input int n);
    retire_i = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; retire_i = 1'b0; io_wait_i = 1'b0; irq_taken_i = 1'b0;
    clr_i = 1'b0; pc_i = '0; fsm_i = '0; vec_i = '0; thresh_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cyc", cyc_cnt_o, 0);
    chk("R1 stall", 64'(stall_cnt_o), 0);
    chk("R1 frozen", 64'(frozen_o), 0);
    chk("R1 snap", {17'd0, snap_st_o, snap_pc_o}, 0);
    rst_n = 1'b1;

    // R2 R3 R4 table walk
    clear();
    for (int k = 0; k < 8; k++) begin
      {retire_i, io_wait_i, irq_taken_i} = TBL[k][18:16];
      tick();
      chk("R2 cyc", cyc_cnt_o, 64'(k + 1));
      chk("R3 ret", ret_cnt_o, 64'(TBL[k][15:12]));
      chk("R4 stall", 64'(stall_cnt_o), 64'(TBL[k][11:8]));
      chk("R4 io", 64'(io_cnt_o), 64'(TBL[k][7:4]));
      chk("R4 irq", 64'(irq_cnt_o), 64'(TBL[k][3:0]));
    end
    io_wait_i = 1'b0; irq_taken_i = 1'b0;

    // R11 live status word
    fsm_i = 6'h2A; vec_i = 8'hC3; io_wait_i = 1'b1;
    #1;
    chk("R11 status", 64'(status_o), 64'(32'h0001_C32A));
    io_wait_i = 1'b0;

    // R6 zero threshold never freezes
    clear();
    thresh_i = '0;
    stalls(40);
    chk("R6 frozen", 64'(frozen_o), 0);

    // R8 retire breaks the run
    clear();
    thresh_i = 5;
    stalls(4);
    retire_i = 1'b1; tick();
    stalls(4);
    chk("R8 frozen", 64'(frozen_o), 0);

    // R7 capture exactly at Nth stall edge
    clear();
    retire_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      pc_i = 32'h100 + 32'(i); fsm_i = 6'(i); vec_i = 8'h40 + 8'(i);
      tick();
      if (i == 3) chk("R7 early", 64'(frozen_o), 0);
    end
    chk("R7 frozen", 64'(frozen_o), 1);
    chk("R7 pc", 64'(snap_pc_o), 64'h104);
    chk("R7 st", 64'(snap_st_o), 64'({1'b1, 8'h44, 6'd4}));
    chk("R11 bit18", 64'(status_o[18]), 1);

    // R9 snapshot persists over later wedge
    retire_i = 1'b1; tick();
    pc_i = 32'hBEEF; fsm_i = 6'h3F; vec_i = 8'hFF;
    stalls(12);
    chk("R9 pc", 64'(snap_pc_o), 64'h104);
    chk("R9 st", 64'(snap_st_o), 64'({1'b1, 8'h44, 6'd4}));

    // R10 clear wins over capture and restarts run
    clear();
    chk("R10 frozen", 64'(frozen_o), 0);
    chk("R10 snap", 64'(snap_pc_o), 0);
    chk("R10 cyc", cyc_cnt_o, 0);
    thresh_i = 3;
    stalls(2);
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    chk("R10 prio", 64'(frozen_o), 0);
    stalls(2);
    chk("R10 run", 64'(frozen_o), 0);
    stalls(1);
    chk("R10 recap", 64'(frozen_o), 1);

    // R5 saturation
    thresh_i = '0;
    clear();
    io_wait_i = 1'b1; irq_taken_i = 1'b1;
    stalls(300);
    chk("R5 stall", 64'(stall_cnt_o), 255);
    chk("R5 io", 64'(io_cnt_o), 255);
    chk("R5 irq", 64'(irq_cnt_o), 255);
    chk("R2 long", cyc_cnt_o, 300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule